// File: doc/BRIEF.md
# Two-Slot Elastic Channel Stage

This block is one stage of an elastic channel. A row of these stages turns a pipelined wire into a FIFO spread along its length. Each stage stores at most two flits. The first sits in a main slot that drives the output. The second sits in a side slot that catches a flit arriving while the output is stalled. The two slots work like the two halves of a master-slave flip-flop. The flit width is set by a parameter.

Both edges use a valid/ready handshake. A flit moves across an edge on a rising clock edge only when the sender's valid and the receiver's ready are both high in that cycle. A sender that sees ready low must keep its flit and its valid in place. The stage never takes a flit offered while its own ready is low.

`in_ready` comes straight from a register and depends only on how many flits the stage holds. It never depends on the same cycle's `out_ready`. Back-pressure therefore travels back one stage per cycle, and no combinational ready path runs the length of a chain. A flit accepted at an edge shows on the output after that same edge.

Top module: `elastic_stage`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties both slots. After that edge `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when the stage holds fewer than two flits.
- R3: `out_valid` is 1 exactly when the stage holds at least one flit. While it is 1, `out_data` is the oldest stored flit.
- R4: A flit moves in only on an edge where `in_valid` and `in_ready` are both 1. A flit moves out only on an edge where `out_valid` and `out_ready` are both 1. A flit offered while `in_ready` is 0 is not stored.
- R5: Flits leave in the order they entered. None is lost and none is duplicated.
- R6: With one flit stored, an edge that both pushes and pops leaves one flit stored, so the stage passes one flit per cycle.
- R7: While the stage is full and `out_ready` is 0, `out_valid` stays 1, `out_data` stays unchanged and `in_ready` stays 0.
- R8: Changing `out_ready` between clock edges never changes `in_ready` before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream offers a flit |
| in_ready | output | 1 | Stage has a free slot |
| in_data | input | WIDTH | Offered flit |
| out_valid | output | 1 | Stage holds at least one flit |
| out_ready | input | 1 | Downstream accepts the flit |
| out_data | output | WIDTH | Oldest stored flit |

## Verification
A wrong occupancy shows at once as a bad `in_ready`/`out_valid` pair. With a false full state, ready stays low on the edge after a pop. With a false empty state, valid drops while a flit is still held. A slot mux that picks the wrong slot shows at the next pop, as an out-of-order or repeated flit. That error is caught by comparing every departing flit with a scoreboard fed by accepted flits, under random stalls on both sides.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_ONE   = 2'd1,
    OCC_TWO   = 2'd2
  } occ_e;

  localparam int unsigned NUM_SLOTS = 2;

  typedef struct packed {
    logic main_load;
    logic main_from_side;
    logic side_load;
  } slot_ctl_t;

endpackage

// File: rtl/ebuf_ctrl.sv
module ebuf_ctrl
  import ebuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      up_valid,
  input  logic      dn_ready,
  output logic      up_ready,
  output logic      dn_valid,
  output slot_ctl_t ctl
);

  occ_e occ_q, occ_d;
  logic ready_q, valid_q;
  logic push, pop;

  assign push = up_valid & ready_q;
  assign pop  = valid_q & dn_ready;

  always_comb begin
    occ_d = occ_q;
    ctl   = '0;
    unique case (occ_q)
      OCC_EMPTY: begin
        if (push) begin
          ctl.main_load = 1'b1;
          occ_d         = OCC_ONE;
        end
      end
      OCC_ONE: begin
        if (push && pop) begin
          ctl.main_load = 1'b1;
        end else if (push) begin
          ctl.side_load = 1'b1;
          occ_d         = OCC_TWO;
        end else if (pop) begin
          occ_d = OCC_EMPTY;
        end
      end
      OCC_TWO: begin
        if (pop) begin
          ctl.main_load      = 1'b1;
          ctl.main_from_side = 1'b1;
          occ_d              = OCC_ONE;
        end
      end
      default: occ_d = OCC_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q   <= OCC_EMPTY;
      ready_q <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      occ_q   <= occ_d;
      ready_q <= (occ_d != OCC_TWO);
      valid_q <= (occ_d != OCC_EMPTY);
    end
  end

  assign up_ready = ready_q;
  assign dn_valid = valid_q;

endmodule

// File: rtl/ebuf_slot.sv
module ebuf_slot #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk) begin
    if (load) q_r <= d;
  end

  assign q = q_r;

endmodule

// File: rtl/elastic_stage.sv
module elastic_stage
  import ebuf_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  slot_ctl_t        ctl;
  logic [WIDTH-1:0] slot_q [NUM_SLOTS];

  ebuf_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .dn_ready (out_ready),
    .up_ready (in_ready),
    .dn_valid (out_valid),
    .ctl      (ctl)
  );

  // slot 0 is the main slot driving the output, slot 1 is the side slot
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_main
      logic [WIDTH-1:0] main_d;
      assign main_d = ctl.main_from_side ? slot_q[1] : in_data;
      ebuf_slot #(.WIDTH(WIDTH)) u_slot (
        .clk  (clk),
        .load (ctl.main_load),
        .d    (main_d),
        .q    (slot_q[g])
      );
    end else begin : g_side
      ebuf_slot #(.WIDTH(WIDTH)) u_slot (
        .clk  (clk),
        .load (ctl.side_load),
        .d    (in_data),
        .q    (slot_q[g])
      );
    end
  end

  assign out_data = slot_q[0];

endmodule

// File: rtl/elastic_stage_chk.sv
module elastic_stage_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data
);

  logic       push, pop;
  logic [1:0] cnt;

  assign push = in_valid & in_ready;
  assign pop  = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (rst) cnt <= 2'd0;
    else if (push && !pop) cnt <= cnt + 2'd1;
    else if (pop && !push) cnt <= cnt - 2'd1;
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));

  // R2
  ready_occ_chk: assert property (@(posedge clk) disable iff (rst) in_ready == (cnt < 2'd2));

  // R3
  valid_occ_chk: assert property (@(posedge clk) disable iff (rst) out_valid == (cnt != 2'd0));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) cnt <= 2'd2);

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd1 && push && pop) |=> (out_valid && in_ready));

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd2 && !out_ready) |=> (out_valid && !in_ready && $stable(out_data)));

  // R5
  stall_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind elastic_stage elastic_stage_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/elastic_stage_tb.sv
module elastic_stage_tb;

  localparam int W = 8;
  localparam int NVEC = 14;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] in_data;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  elastic_stage #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // {in_valid, in_data, out_ready, exp_in_ready, exp_out_valid, exp_out_data}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b1, 8'h22, 1'b0, 1'b1, 1'b1, 8'h11},
    {1'b1, 8'h33, 1'b0, 1'b0, 1'b1, 8'h11},
    {1'b1, 8'h33, 1'b1, 1'b0, 1'b1, 8'h11},
    {1'b1, 8'h33, 1'b1, 1'b1, 1'b1, 8'h22},
    {1'b1, 8'h44, 1'b1, 1'b1, 1'b1, 8'h33},
    {1'b0, 8'h55, 1'b1, 1'b1, 1'b1, 8'h44},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00},
    {1'b1, 8'h66, 1'b1, 1'b1, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h66},
    {1'b1, 8'h77, 1'b0, 1'b1, 1'b1, 8'h66},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h66},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h77},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic [W-1:0] id, input logic ordy);
    @(negedge clk);
    in_valid  = iv;
    in_data   = id;
    out_ready = ordy;
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1: state after reset
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(in_ready, "R1 in_ready after reset", in_ready, 1);

    // Table walk: R2 R3 R4 R6 (row 2-3 offer 33 while full: taken once, in order)
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][19], VEC[i][18:11], VEC[i][10]);
      check(in_ready == VEC[i][9], "R2 in_ready table", in_ready, VEC[i][9]);
      check(out_valid == VEC[i][8], "R3 out_valid table", out_valid, VEC[i][8]);
      if (VEC[i][8])
        check(out_data == VEC[i][7:0], "R4 R5 out_data table", out_data, VEC[i][7:0]);
    end

    // R7 and R8: fill, then hold with out_ready low
    drive(1'b1, 8'hA1, 1'b0);
    drive(1'b1, 8'hA2, 1'b0);
    drive(1'b1, 8'hA3, 1'b0);
    for (int k = 0; k < 4; k++) begin
      check(out_valid && out_data == 8'hA1, "R7 full hold data", out_data, 8'hA1);
      check(!in_ready, "R7 full hold ready", in_ready, 0);
      out_ready = 1'b1;
      #1;
      check(!in_ready, "R8 in_ready ignores out_ready", in_ready, 0);
      out_ready = 1'b0;
      @(negedge clk);
      #2;
    end

    // R1: reset while full
    do_reset();
    #2;
    check(!out_valid, "R1 out_valid after full reset", out_valid, 0);
    check(in_ready, "R1 in_ready after full reset", in_ready, 1);

    // R6: continuous stream, one flit per cycle
    drive(1'b1, 8'h80, 1'b1);
    for (int k = 1; k < 20; k++) begin
      drive(1'b1, W'(8'h80 + k), 1'b1);
      check(in_ready && out_valid, "R6 streaming handshake", {in_ready, out_valid}, 3);
      check(out_data == W'(8'h80 + k - 1), "R6 streaming data", out_data, 8'h80 + k - 1);
    end
    drive(1'b0, 8'h00, 1'b1);
    drive(1'b0, 8'h00, 1'b1);

    // R5: random stalls on both sides against a scoreboard
    do_reset();
    begin
      logic [15:0] lfsr = 16'hACE1;
      logic [W-1:0] send = 8'h01;
      logic [W-1:0] recv = 8'h01;
      int occ = 0;
      int got = 0;
      for (int c = 0; c < 400; c++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        drive(lfsr[0] | lfsr[3], send, lfsr[5] | lfsr[7]);
        check(in_ready == (occ < 2), "R2 random ready", in_ready, occ < 2);
        check(out_valid == (occ != 0), "R3 random valid", out_valid, occ != 0);
        if (out_valid && out_ready) begin
          check(out_data == recv, "R5 random order", out_data, recv);
          recv = recv + 1'b1;
          got++;
          occ--;
        end
        if (in_valid && in_ready) begin
          send = send + 1'b1;
          occ++;
        end
      end
      check(got > 50, "R5 random throughput", got, 50);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule